// File: doc/BRIEF.md
# Strobed Pixel Write Port

This block sits between a slow external processor and the write side of a framebuffer memory arbiter. The processor drives a narrow five-bit port: three colour bits, an address-clear bit and a write strobe. None of these pins is timed to the system clock. The block brings all five pins into the system clock domain through a two-stage synchronizer. It acts only on rising edges of the synchronized strobe. It keeps an auto-incrementing 18-bit framebuffer address.

Each pixel write turns into one request on a valid/ready output stream that carries the address and the colour. The arbiter that consumes it gives writes priority over display reads, so the write side normally drains quickly. The request still waits if `wr_ready_i` is held low. A payload is transferred on any clock edge where `wr_valid_o` and `wr_ready_i` are both high. While valid is high and ready is low, the request and its payload stay frozen.

If a new strobe edge arrives while a request is stalled, the new write is discarded. The block then raises a sticky overrun flag, so the loss is visible rather than silent.

Top module: `pixel_wr_port`

## Requirements
- R1: A synchronous active-high `rst` clears the request, the overrun flag and the address pointer. After reset, the first accepted pixel goes to address 0. `cpu_port_i` bit 4 must be low while `rst` is high.
- R2: Every port pin passes through two flops. If the strobe (bit 4) rises just before clock edge E1, `wr_valid_o` is high after edge E3 and low after edge E2.
- R3: A strobe rising edge with bit 3 low issues a request. Its `wr_color_o` equals bits 2..0 and its `wr_addr_o` equals the current pointer. The pointer then advances by one.
- R4: A strobe rising edge with bit 3 high clears the pointer to zero and issues no request.
- R5: While `wr_valid_o` is high and `wr_ready_i` is low, the request, address and colour hold their values. After an accepted transfer with no new edge, `wr_valid_o` is low on the next cycle.
- R6: Only rising edges of the strobe act. A strobe held high, or a falling strobe, issues nothing.
- R7: A write edge that arrives while a request is pending and not being accepted does the following: it sets `overrun_o`, it leaves the pending payload unchanged, and it leaves the pointer unadvanced.
- R8: A write edge that arrives in the same cycle the pending request is accepted loads the new request without setting `overrun_o`.
- R9: An address-clear edge while a request is pending clears the pointer but leaves the pending payload unchanged and does not set `overrun_o`.
- R10: Once set, `overrun_o` stays high until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_port_i | input | 5 | Asynchronous processor port: [4] strobe, [3] address clear, [2:0] colour |
| wr_ready_i | input | 1 | Arbiter accepts the write request |
| wr_valid_o | output | 1 | Write request pending |
| wr_addr_o | output | 18 | Framebuffer address of the pending write |
| wr_color_o | output | 3 | Colour of the pending write |
| overrun_o | output | 1 | Sticky flag: a write was discarded |

## Verification
The bench aims at the collisions between a new strobe edge and a request that is already pending:
- An edge during a stall must be discarded and flagged. A design that overwrote the payload would lose the earlier pixel. A design that advanced the pointer would shift every later pixel by one.
- An edge that lands exactly on the accepting cycle must be taken. A design that flagged it would report a false overrun and drop the pixel.
- An address clear during a stall must touch only the pointer.

Long strobe-high holds are checked to expose a level-sensitive design, which would issue repeated writes. The three-cycle latency check exposes a missing or extra synchronizer stage. Random pixel runs with random arbiter stalls track the pointer across hundreds of writes.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  localparam int COLOR_W = 3;

  // Bit order matches the processor port: [4] strobe, [3] clear, [2:0] colour.
  typedef struct packed {
    logic               stb;
    logic               clr;
    logic [COLOR_W-1:0] color;
  } cpu_port_t;

  localparam int PORT_W = $bits(cpu_port_t);
endpackage

// File: rtl/pwp_sync.sv
module pwp_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pwp_edge.sv
module pwp_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/pwp_addr_ctr.sv
module pwp_addr_ctr #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) ptr_q <= '0;
    else if (inc_i)   ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i) |=> ptr_q == AW'($past(ptr_q) + 1'b1)); // R3
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ptr_q == '0); // R4
endmodule

// File: rtl/pixel_wr_port.sv
module pixel_wr_port #(
  parameter int AW          = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [pwp_pkg::PORT_W-1:0]  cpu_port_i,
  input  logic                        wr_ready_i,
  output logic                        wr_valid_o,
  output logic [AW-1:0]               wr_addr_o,
  output logic [pwp_pkg::COLOR_W-1:0] wr_color_o,
  output logic                        overrun_o
);
  import pwp_pkg::*;

  logic [PORT_W-1:0]  port_sync;
  cpu_port_t          port_s;
  logic               stb_rise;
  logic               wr_edge;
  logic               clr_edge;
  logic               accept;
  logic               load;
  logic               drop;
  logic [AW-1:0]      ptr;
  logic               valid_q;
  logic [AW-1:0]      addr_q;
  logic [COLOR_W-1:0] color_q;
  logic               ovr_q;

  pwp_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_i(cpu_port_i), .q_o(port_sync)
  );

  assign port_s = cpu_port_t'(port_sync);

  pwp_edge edge_i (
    .clk(clk), .rst(rst), .lvl_i(port_s.stb), .rise_o(stb_rise)
  );

  // Clear and colour come from the same synchronized word as the strobe edge.
  assign wr_edge  = stb_rise & ~port_s.clr;
  assign clr_edge = stb_rise &  port_s.clr;
  assign accept   = valid_q & wr_ready_i;
  assign load     = wr_edge & (~valid_q | wr_ready_i);
  assign drop     = wr_edge & valid_q & ~wr_ready_i;

  pwp_addr_ctr #(.AW(AW)) ctr_i (
    .clk(clk), .rst(rst), .clr_i(clr_edge), .inc_i(load), .ptr_o(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      color_q <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      addr_q  <= ptr;
      color_q <= port_s.color;
    end else if (accept) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       ovr_q <= 1'b0;
    else if (drop) ovr_q <= 1'b1;
  end

  assign wr_valid_o = valid_q;
  assign wr_addr_o  = addr_q;
  assign wr_color_o = color_q;
  assign overrun_o  = ovr_q;

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_color_o))); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o); // R10
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (!wr_valid_o && !overrun_o)); // R1
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_o) |-> $past(wr_valid_o && !wr_ready_i)); // R7
endmodule

// File: tb/pixel_wr_port_tb_top.sv
`timescale 1ns/1ps
module pixel_wr_port_tb_top;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    port = '0;
  logic          ready = 1'b0;
  logic          valid;
  logic [AW-1:0] addr;
  logic [2:0]    color;
  logic          ovr;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;
  logic [AW-1:0] exp_ptr = '0;

  always #2.5 clk = ~clk;

  pixel_wr_port #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cpu_port_i(port), .wr_ready_i(ready),
    .wr_valid_o(valid), .wr_addr_o(addr), .wr_color_o(color), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; port = '0; ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    exp_ptr = '0;
  endtask

  // Strobe low with data, then rise; returns at the negedge after the third posedge.
  task automatic strobe(input bit clr, input logic [2:0] col);
    @(negedge clk);
    port = {1'b0, clr, col};
    repeat (3) @(negedge clk);
    port[4] = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0;
  endtask

  task automatic expect_req(input logic [AW-1:0] a, input logic [2:0] c, input string req);
    chk(valid === 1'b1, req, valid, 1);
    chk(addr === a, req, addr, a);
    chk(color === c, req, color, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    chk(valid === 1'b0, "R1 valid", valid, 0);
    chk(ovr === 1'b0, "R1 overrun", ovr, 0);

    // R2 latency: strobe rises at negedge, valid low after E2, high after E3
    @(negedge clk); port = 5'b00101;
    repeat (3) @(negedge clk);
    port[4] = 1'b1;
    repeat (2) @(negedge clk);
    chk(valid === 1'b0, "R2 early", valid, 0);
    @(negedge clk);
    expect_req('0, 3'd5, "R2/R1 first addr");
    exp_ptr = next_addr(exp_ptr);
    accept();
    chk(valid === 1'b0, "R5 drop after accept", valid, 0);

    // R6 strobe held high, then falls: nothing issued
    repeat (6) @(negedge clk);
    chk(valid === 1'b0, "R6 held high", valid, 0);
    port[4] = 1'b0;
    repeat (5) @(negedge clk);
    chk(valid === 1'b0, "R6 falling", valid, 0);

    // R3 next write uses incremented pointer; R5 hold while stalled
    strobe(1'b0, 3'd2);
    expect_req(exp_ptr, 3'd2, "R3 second write");
    repeat (4) @(negedge clk);
    expect_req(exp_ptr, 3'd2, "R5 held");
    exp_ptr = next_addr(exp_ptr);

    // R7 edge during stall: discarded, flagged, pointer not advanced
    strobe(1'b0, 3'd7);
    chk(ovr === 1'b1, "R7 overrun", ovr, 1);
    expect_req(AW'(1), 3'd2, "R7 payload kept");
    accept();
    chk(valid === 1'b0, "R7 no extra", valid, 0);
    strobe(1'b0, 3'd6);
    expect_req(exp_ptr, 3'd6, "R7 pointer unchanged");
    exp_ptr = next_addr(exp_ptr);

    // R9 clear during stall
    strobe(1'b1, 3'd0);
    expect_req(AW'(2), 3'd6, "R9 payload kept");
    exp_ptr = '0;
    accept();
    strobe(1'b0, 3'd3);
    expect_req('0, 3'd3, "R9/R4 pointer cleared");
    exp_ptr = next_addr(exp_ptr);

    // R8 edge on the accepting cycle
    @(negedge clk); port = 5'b00001;
    repeat (3) @(negedge clk);
    port[4] = 1'b1;
    repeat (2) @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    expect_req(exp_ptr, 3'd1, "R8 loaded on accept");
    exp_ptr = next_addr(exp_ptr);
    accept();

    // R10 flag still set (from R7), cleared only by reset
    repeat (3) @(negedge clk);
    chk(ovr === 1'b1, "R10 sticky", ovr, 1);
    do_reset();
    chk(ovr === 1'b0, "R10/R1 cleared by reset", ovr, 0);

    // R4 clear edge alone issues nothing
    strobe(1'b0, 3'd4);
    exp_ptr = next_addr(exp_ptr);
    accept();
    strobe(1'b1, 3'd4);
    chk(valid === 1'b0, "R4 no request", valid, 0);
    exp_ptr = '0;

    // Random pixels with random arbiter stalls
    for (int i = 0; i < 300; i++) begin
      bit         clr;
      logic [2:0] col;
      int         stall;
      clr   = ($urandom % 8) == 0;
      col   = 3'($urandom);
      stall = $urandom % 4;
      strobe(clr, col);
      if (clr) begin
        chk(valid === 1'b0, "R4 random clear", valid, 0);
        exp_ptr = '0;
      end else begin
        expect_req(exp_ptr, col, "R3 random write");
        repeat (stall) @(negedge clk);
        expect_req(exp_ptr, col, "R5 random stall");
        exp_ptr = next_addr(exp_ptr);
        accept();
        chk(valid === 1'b0, "R5 random accept", valid, 0);
      end
      chk(ovr === 1'b0, "R7 no false overrun", ovr, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule